// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block decides, every cycle, which stages of an in-order eight-stage pipeline (F1, F2, D1, D2, X, M1, M2, WB) hold their contents, which stages lose their instruction, and whether fetch must restart at a new address. It looks at the stage valid bits, the instruction class held in the decode and execute stages, the register indices of the instruction in D2 and of the producers in X and M1, the target-buffer hit and direction prediction recorded for the instructions in D1 and D2, and the branch and jump resolution results.

Three events are handled. The first is a load followed closely by a reader of its destination register. Load data is usable only after M2, so the reader waits in D2 and bubbles go into X. The second is a jump that missed in the target buffer at fetch. It is resolved in D1 and costs two wrong-path slots. The third is a conditional branch whose fetch-time guess of direction or target was wrong. It is resolved in D2 and costs three slots. The outputs are combinational from the current stage contents. The pipeline registers act on them at the next clock edge, so the pipeline changes state only on that edge. A target-buffer hit on a jump, or a correct guess on a branch, costs nothing.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no valid instruction in any stage (including directly after reset), `stg_hold`, `stg_flush` and `redir_vld` are all zero. `redir_tgt` is zero in every cycle without a redirect. Bit i of `stg_hold` and `stg_flush` refers to stage i, with F1=0, F2=1, D1=2, D2=3, X=4, M1=5, M2=6, WB=7.
- R2: A valid instruction in D2 whose rs1 or rs2 equals the destination of a valid load (class code 1) in X or M1 raises `stg_hold` bits 0 to 3 and no other hold bit, so X takes a bubble. A reader directly behind its load waits 2 cycles in D2, and a reader one slot behind waits 1 cycle.
- R3: Register index 0 never creates a dependency. A producer that is not a load never causes a hold.
- R4: A jump (class code 3) in D1 that hit in the target buffer causes no flush and no redirect.
- R5: A valid jump in D1 that missed in the target buffer, with no hold active, sets `redir_vld` with `redir_tgt` equal to `d1_jmp_tgt`. It also flushes F1 and F2, each bit raised only when that stage is valid.
- R6: A valid branch (class code 2) in D2 with no hold active redirects when its fetch-time direction was wrong. The fetch-time direction is taken only if both `d2_pred_taken` and `d2_btb_hit` are set. The redirect flushes the valid stages among F1, F2 and D1. `redir_tgt` is `d2_br_tgt` when the branch is taken and `d2_seq_pc` when it is not.
- R7: A branch predicted taken but missing in the target buffer, when actually taken, redirects. So does a branch predicted taken with a target-buffer hit whose `d2_pred_tgt` differs from `d2_br_tgt`. A correctly guessed branch causes nothing.
- R8: When a branch redirect in D2 and a jump redirect in D1 arise in the same cycle, the branch target is used and the jump in D1 is flushed.
- R9: While a load-use hold is active, no redirect is raised. A jump or branch waiting behind the held reader resolves after the hold ends.
- R10: A program runs in its hazard-free cycle count plus 2 per adjacent load-use pair, 1 per gapped pair, 2 per jump miss and 3 per branch redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, qualifies the checks |
| stg_vld | input | 6 | Valid bits of F1..M1 (bit 0 = F1) |
| d1_cls | input | 2 | Class of the instruction in D1 |
| d2_cls | input | 2 | Class of the instruction in D2 |
| x_cls | input | 2 | Class of the instruction in X |
| m1_cls | input | 2 | Class of the instruction in M1 |
| x_rd | input | RW | Destination register in X |
| m1_rd | input | RW | Destination register in M1 |
| d2_rs1 | input | RW | First source register in D2 (0 if unused) |
| d2_rs2 | input | RW | Second source register in D2 (0 if unused) |
| d1_btb_hit | input | 1 | Target-buffer hit recorded for the D1 instruction |
| d1_jmp_tgt | input | AW | Decoded jump target in D1 |
| d2_btb_hit | input | 1 | Target-buffer hit recorded for the D2 instruction |
| d2_pred_taken | input | 1 | Direction guessed at fetch for the D2 branch |
| d2_pred_tgt | input | AW | Target supplied by the target buffer for the D2 branch |
| d2_br_taken | input | 1 | Resolved direction of the D2 branch |
| d2_br_tgt | input | AW | Resolved taken target of the D2 branch |
| d2_seq_pc | input | AW | Fall-through address of the D2 branch |
| stg_hold | output | 8 | Per-stage hold enables |
| stg_flush | output | 8 | Per-stage squash of the current instruction |
| redir_vld | output | 1 | Fetch redirect this cycle |
| redir_tgt | output | AW | Redirect address, zero when idle |

## Verification
The in-RTL assertions watch the invariants that hold in every cycle. A hold never coexists with a redirect, and a hold always has a valid load in X or M1 behind it. A redirect always clears the younger fetch stages. Zero sources never hold. A well-guessed branch or a target-buffer hit jump stays quiet, and a branch override always carries a branch address. The exact number of stall cycles per pair, the deferral of a jump or branch waiting behind a held reader, and the total cycle cost of each hazard mix show up only in the bench's instruction streams. There, a behavioural pipeline model is compared with the outputs on every clock.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int NSTG  = 8;
  localparam int ST_F1 = 0;
  localparam int ST_F2 = 1;
  localparam int ST_D1 = 2;
  localparam int ST_D2 = 3;
  localparam int ST_X  = 4;
  localparam int ST_M1 = 5;
  localparam int ST_M2 = 6;
  localparam int ST_WB = 7;
  // valid bits needed: fetch through first memory stage
  localparam int VLD_W = ST_M1 + 1;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_JUMP   = 2'd3
  } iclass_e;
endpackage

// File: rtl/phc_loaduse_det.sv
module phc_loaduse_det #(
  parameter int RW    = 5,
  parameter int NPROD = 2,
  parameter int NSRC  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cons_vld_i,
  input  logic [NSRC-1:0][RW-1:0]    src_i,
  input  logic [NPROD-1:0]           prod_ld_i,
  input  logic [NPROD-1:0][RW-1:0]   prod_rd_i,
  output logic                       hazard_o
);
  localparam int NPAIR = NPROD * NSRC;

  logic [NPAIR-1:0] pair_hit;

  // one comparator per (producer, source) pair
  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign pair_hit[p*NSRC+s] = prod_ld_i[p]
                                 && (src_i[s] != '0)
                                 && (src_i[s] == prod_rd_i[p]);
    end
  end

  assign hazard_o = cons_vld_i && (|pair_hit);

  // R3
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> !hazard_o);
endmodule

// File: rtl/phc_branch_res.sv
module phc_branch_res #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          btb_hit_i,
  input  logic          pred_taken_i,
  input  logic [AW-1:0] pred_tgt_i,
  input  logic          taken_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] seq_pc_i,
  output logic          redir_o,
  output logic [AW-1:0] tgt_o
);
  logic fetched_taken;
  logic dir_wrong;
  logic addr_wrong;

  // fetch only followed a taken guess if the buffer also had a target
  assign fetched_taken = pred_taken_i & btb_hit_i;
  assign dir_wrong     = fetched_taken ^ taken_i;
  assign addr_wrong    = taken_i & fetched_taken & (pred_tgt_i != tgt_i);
  assign redir_o       = en_i & (dir_wrong | addr_wrong);
  assign tgt_o         = taken_i ? tgt_i : seq_pc_i;

  // R7
  good_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && btb_hit_i && pred_taken_i && taken_i && (pred_tgt_i == tgt_i)) |-> !redir_o);
  // R7
  good_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !taken_i && !(pred_taken_i && btb_hit_i)) |-> !redir_o);
  // R6
  miss_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && taken_i && !btb_hit_i) |-> (redir_o && (tgt_o == tgt_i)));
endmodule

// File: rtl/phc_jump_res.sv
module phc_jump_res #(
  parameter int AW = 32
) (
  input  logic          en_i,
  input  logic          btb_hit_i,
  input  logic [AW-1:0] tgt_i,
  output logic          redir_o,
  output logic [AW-1:0] tgt_o
);
  // a buffer hit already steered fetch; only a miss needs correction
  assign redir_o = en_i & ~btb_hit_i;
  assign tgt_o   = tgt_i;
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import phc_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VLD_W-1:0]  stg_vld,
  input  logic [CLS_W-1:0]  d1_cls,
  input  logic [CLS_W-1:0]  d2_cls,
  input  logic [CLS_W-1:0]  x_cls,
  input  logic [CLS_W-1:0]  m1_cls,
  input  logic [RW-1:0]     x_rd,
  input  logic [RW-1:0]     m1_rd,
  input  logic [RW-1:0]     d2_rs1,
  input  logic [RW-1:0]     d2_rs2,
  input  logic              d1_btb_hit,
  input  logic [AW-1:0]     d1_jmp_tgt,
  input  logic              d2_btb_hit,
  input  logic              d2_pred_taken,
  input  logic [AW-1:0]     d2_pred_tgt,
  input  logic              d2_br_taken,
  input  logic [AW-1:0]     d2_br_tgt,
  input  logic [AW-1:0]     d2_seq_pc,
  output logic [NSTG-1:0]   stg_hold,
  output logic [NSTG-1:0]   stg_flush,
  output logic              redir_vld,
  output logic [AW-1:0]     redir_tgt
);
  localparam int NPROD = 2;
  localparam int NSRC  = 2;

  logic                       lu_stall;
  logic [NSRC-1:0][RW-1:0]    d2_srcs;
  logic [NPROD-1:0]           prod_ld;
  logic [NPROD-1:0][RW-1:0]   prod_rd;
  logic                       br_en;
  logic                       jmp_en;
  logic                       br_fix;
  logic                       jmp_fix;
  logic [AW-1:0]              br_addr;
  logic [AW-1:0]              jmp_addr;
  logic                       br_win;
  logic                       jmp_win;

  // ---------------- load-use detection (D2 against X, M1) ----------------
  assign d2_srcs[0] = d2_rs1;
  assign d2_srcs[1] = d2_rs2;
  assign prod_ld[0] = stg_vld[ST_X]  && (x_cls  == CLS_LOAD);
  assign prod_ld[1] = stg_vld[ST_M1] && (m1_cls == CLS_LOAD);
  assign prod_rd[0] = x_rd;
  assign prod_rd[1] = m1_rd;

  phc_loaduse_det #(.RW(RW), .NPROD(NPROD), .NSRC(NSRC)) u_lu (
    .clk        (clk),
    .rst_n      (rst_n),
    .cons_vld_i (stg_vld[ST_D2]),
    .src_i      (d2_srcs),
    .prod_ld_i  (prod_ld),
    .prod_rd_i  (prod_rd),
    .hazard_o   (lu_stall)
  );

  // ---------------- control-flow resolution ----------------
  // a held D2/D1 instruction does not resolve until the hold releases
  assign br_en  = stg_vld[ST_D2] && (d2_cls == CLS_BRANCH) && !lu_stall;
  assign jmp_en = stg_vld[ST_D1] && (d1_cls == CLS_JUMP)   && !lu_stall;

  phc_branch_res #(.AW(AW)) u_br (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (br_en),
    .btb_hit_i    (d2_btb_hit),
    .pred_taken_i (d2_pred_taken),
    .pred_tgt_i   (d2_pred_tgt),
    .taken_i      (d2_br_taken),
    .tgt_i        (d2_br_tgt),
    .seq_pc_i     (d2_seq_pc),
    .redir_o      (br_fix),
    .tgt_o        (br_addr)
  );

  phc_jump_res #(.AW(AW)) u_jmp (
    .en_i      (jmp_en),
    .btb_hit_i (d1_btb_hit),
    .tgt_i     (d1_jmp_tgt),
    .redir_o   (jmp_fix),
    .tgt_o     (jmp_addr)
  );

  // older instruction (D2 branch) takes precedence over the D1 jump
  assign br_win    = br_fix;
  assign jmp_win   = jmp_fix && !br_fix;
  assign redir_vld = br_win | jmp_win;
  assign redir_tgt = br_win ? br_addr : (jmp_win ? jmp_addr : '0);

  // ---------------- per-stage hold / squash ----------------
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    if (s <= ST_D2) begin : g_front
      assign stg_hold[s] = lu_stall;
    end else begin : g_back
      assign stg_hold[s] = 1'b0;
    end

    if (s < ST_D1) begin : g_fetch_kill
      assign stg_flush[s] = stg_vld[s] & redir_vld;
    end else if (s == ST_D1) begin : g_dec_kill
      assign stg_flush[s] = stg_vld[s] & br_win;
    end else begin : g_no_kill
      assign stg_flush[s] = 1'b0;
    end
  end

  // R9
  hold_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_hold[ST_D2] |-> !redir_vld);
  // R2
  hold_has_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_hold[ST_D2] |-> ((stg_vld[ST_X] && x_cls == CLS_LOAD) ||
                         (stg_vld[ST_M1] && m1_cls == CLS_LOAD)));
  // R5
  redir_kills_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> ((stg_flush[ST_F1] == stg_vld[ST_F1]) &&
                   (stg_flush[ST_F2] == stg_vld[ST_F2])));
  // R8
  d1_kill_is_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && stg_flush[ST_D1]) |-> ((redir_tgt == d2_br_tgt) || (redir_tgt == d2_seq_pc)));
  // R4
  jump_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_vld[ST_D1] && d1_cls == CLS_JUMP && d1_btb_hit) |-> (!redir_vld || stg_flush[ST_D1]));
  // R1
  idle_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_vld |-> (redir_tgt == '0));
endmodule

// File: tb/pipe_hazard_ctl_tb.sv
module pipe_hazard_ctl_tb;
  import phc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [VLD_W-1:0] stg_vld;
  logic [1:0] d1_cls, d2_cls, x_cls, m1_cls;
  logic [RW-1:0] x_rd, m1_rd, d2_rs1, d2_rs2;
  logic d1_btb_hit, d2_btb_hit, d2_pred_taken, d2_br_taken;
  logic [AW-1:0] d1_jmp_tgt, d2_pred_tgt, d2_br_tgt, d2_seq_pc;
  logic [NSTG-1:0] stg_hold, stg_flush;
  logic redir_vld;
  logic [AW-1:0] redir_tgt;

  pipe_hazard_ctl #(.AW(AW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld),
    .d1_cls(d1_cls), .d2_cls(d2_cls), .x_cls(x_cls), .m1_cls(m1_cls),
    .x_rd(x_rd), .m1_rd(m1_rd), .d2_rs1(d2_rs1), .d2_rs2(d2_rs2),
    .d1_btb_hit(d1_btb_hit), .d1_jmp_tgt(d1_jmp_tgt),
    .d2_btb_hit(d2_btb_hit), .d2_pred_taken(d2_pred_taken),
    .d2_pred_tgt(d2_pred_tgt), .d2_br_taken(d2_br_taken),
    .d2_br_tgt(d2_br_tgt), .d2_seq_pc(d2_seq_pc),
    .stg_hold(stg_hold), .stg_flush(stg_flush),
    .redir_vld(redir_vld), .redir_tgt(redir_tgt)
  );

  typedef struct {
    logic v; logic [1:0] cls; logic [4:0] rd, rs1, rs2;
    logic bh, pt, at, badt, jb, junk; logic [31:0] pc, tgt;
  } ins_t;

  ins_t st[8];
  ins_t prog[64];
  int plen, pidx, retired, last_cyc, offset;
  bit wp, jbp;
  int n_chk = 0, n_err = 0, gcyc = 0;
  logic [7:0] e_hold, e_flush;
  logic e_redir;
  logic [31:0] e_tgt;

  function automatic ins_t empty_ins();
    ins_t e = '{default: '0};
    return e;
  endfunction

  function automatic bit wrong_guess(ins_t e);
    return (e.at != (e.pt & e.bh)) || (e.at & e.pt & e.bh & e.badt);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [1:0] cls, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2,
                     logic bh, logic pt, logic at, logic badt, logic jb);
    ins_t e = '{default: '0};
    e.v = 1; e.cls = cls; e.rd = rd; e.rs1 = rs1; e.rs2 = rs2;
    e.bh = bh; e.pt = pt; e.at = at; e.badt = badt; e.jb = jb;
    e.pc = 32'h100 + 32'(plen) * 4;
    e.tgt = 32'h4000 + 32'(plen) * 16;
    prog[plen] = e;
    plen++;
  endtask

  task automatic alu(logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    put(2'd0, rd, a, b, 0, 0, 0, 0, 0);
  endtask
  task automatic ld(logic [4:0] rd);
    put(2'd1, rd, 5'd1, 5'd0, 0, 0, 0, 0, 0);
  endtask
  task automatic jmp(logic hit);
    put(2'd3, 5'd0, 5'd0, 5'd0, hit, 0, 0, 0, 0);
  endtask
  task automatic br(logic bh, logic pt, logic at, logic badt, logic jb);
    put(2'd2, 5'd0, 5'd0, 5'd0, bh, pt, at, badt, jb);
  endtask
  task automatic pad();
    alu(5'd20, 5'd0, 5'd0);
    alu(5'd21, 5'd0, 5'd0);
  endtask

  task automatic drive();
    for (int s = 0; s < VLD_W; s++) stg_vld[s] = st[s].v;
    d1_cls = st[2].cls; d2_cls = st[3].cls; x_cls = st[4].cls; m1_cls = st[5].cls;
    x_rd = st[4].rd; m1_rd = st[5].rd;
    d2_rs1 = st[3].rs1; d2_rs2 = st[3].rs2;
    d1_btb_hit = st[2].bh; d1_jmp_tgt = st[2].tgt;
    d2_btb_hit = st[3].bh; d2_pred_taken = st[3].pt;
    d2_pred_tgt = st[3].badt ? st[3].tgt + 32'h40 : st[3].tgt;
    d2_br_taken = st[3].at; d2_br_tgt = st[3].tgt; d2_seq_pc = st[3].pc + 4;
  endtask

  task automatic fetch(output ins_t e);
    e = empty_ins();
    if (wp) begin
      e.v = 1; e.junk = 1; e.pc = 32'hBAD0;
      if (jbp) begin
        e.cls = 2'd3; e.tgt = 32'hDEAD0000; jbp = 0;
      end
    end else if (pidx < plen) begin
      e = prog[pidx];
      pidx++;
      if ((e.cls == 2'd3 && !e.bh) || (e.cls == 2'd2 && wrong_guess(e))) wp = 1;
      if (e.cls == 2'd2 && e.jb) jbp = 1;
    end
  endtask

  task automatic compare(string stag);
    bit lu, brr, jm;
    string tag;
    lu = 0;
    if (st[3].v)
      for (int p = 4; p <= 5; p++)
        if (st[p].v && st[p].cls == 2'd1 && st[p].rd != 0 &&
            (st[p].rd == st[3].rs1 || st[p].rd == st[3].rs2)) lu = 1;
    brr = !lu && st[3].v && st[3].cls == 2'd2 && wrong_guess(st[3]);
    jm  = !lu && !brr && st[2].v && st[2].cls == 2'd3 && !st[2].bh;
    e_hold = lu ? 8'h0F : 8'h00;
    e_flush = 8'h00;
    for (int s = 0; s < 3; s++)
      if (st[s].v && (brr || (jm && s < 2))) e_flush[s] = 1'b1;
    e_redir = brr || jm;
    e_tgt = brr ? (st[3].at ? st[3].tgt : st[3].pc + 4) : (jm ? st[2].tgt : 32'h0);
    tag = lu ? "R2" : (brr ? "R6" : (jm ? "R5" : stag));
    chk(tag, "hold", 64'(stg_hold), 64'(e_hold));
    chk(tag, "flush", 64'(stg_flush), 64'(e_flush));
    chk(tag, "redir", 64'(redir_vld), 64'(e_redir));
    chk(tag, "target", 64'(redir_tgt), 64'(e_tgt));
  endtask

  task automatic advance();
    ins_t nx[8];
    if (st[7].v && !st[7].junk) retired++;
    for (int s = 7; s >= 1; s--) begin
      if (e_hold[s]) nx[s] = st[s];
      else if (e_hold[s-1]) nx[s] = empty_ins();
      else if (e_flush[s-1]) nx[s] = empty_ins();
      else nx[s] = st[s-1];
    end
    if (e_redir) begin wp = 0; jbp = 0; end
    if (e_hold[0]) nx[0] = st[0];
    else fetch(nx[0]);
    for (int s = 0; s < 8; s++) st[s] = nx[s];
  endtask

  task automatic run(string stag, int pen, bit check_len);
    for (int s = 0; s < 8; s++) st[s] = empty_ins();
    pidx = 0; wp = 0; jbp = 0; retired = 0; last_cyc = 0;
    drive();
    while (retired < plen && last_cyc < 400) begin
      @(negedge clk);
      compare(stag);
      @(posedge clk);
      #1;
      advance();
      drive();
      last_cyc++;
    end
    // R10: total cycle cost of the hazard mix
    if (check_len) chk("R10", {stag, " cycles"}, 64'(last_cyc), 64'(plen + offset + pen));
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000", gcyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) st[s] = empty_ins();
    plen = 0;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: empty pipeline after reset
    chk("R1", "reset hold", 64'(stg_hold), 64'h0);
    chk("R1", "reset flush", 64'(stg_flush), 64'h0);
    chk("R1", "reset redir", 64'(redir_vld), 64'h0);
    chk("R1", "reset target", 64'(redir_tgt), 64'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // baseline: hazard-free stream sets the fill offset
    plen = 0;
    for (int i = 0; i < 6; i++) alu(5'(i + 2), 5'd0, 5'd0);
    run("R1", 0, 0);
    offset = last_cyc - plen;

    // R2: adjacent pair (+2), gapped pair (+1), rs2 match (+2)
    plen = 0;
    ld(5'd5); alu(5'd6, 5'd5, 5'd0); pad();
    ld(5'd9); alu(5'd10, 5'd0, 5'd0); alu(5'd11, 5'd0, 5'd9); pad();
    ld(5'd12); alu(5'd13, 5'd0, 5'd12); pad();
    run("R2", 5, 1);

    // R3: zero register and non-load producer never hold
    plen = 0;
    ld(5'd0); alu(5'd1, 5'd0, 5'd0);
    alu(5'd3, 5'd0, 5'd0); alu(5'd4, 5'd3, 5'd3);
    ld(5'd7); alu(5'd8, 5'd6, 5'd2); pad();
    run("R3", 0, 1);

    // R4: jump that hit in the target buffer
    plen = 0;
    jmp(1); pad();
    run("R4", 0, 1);

    // R5: jump that missed
    plen = 0;
    jmp(0); pad();
    run("R5", 2, 1);

    // R6: taken guessed not-taken, and not-taken guessed taken
    plen = 0;
    br(0, 0, 1, 0, 0); pad();
    br(1, 1, 0, 0, 0); pad();
    run("R6", 6, 1);

    // R7: buffer miss on taken guess, wrong target, then four correct guesses
    plen = 0;
    br(0, 1, 1, 0, 0); pad();
    br(1, 1, 1, 1, 0); pad();
    br(1, 1, 1, 0, 0); pad();
    br(0, 0, 0, 0, 0); pad();
    br(1, 0, 0, 0, 0); pad();
    br(0, 1, 0, 0, 0); pad();
    run("R7", 6, 1);

    // R8: mispredicted branch with a missing jump right behind it
    plen = 0;
    br(0, 0, 1, 0, 1); pad();
    run("R8", 3, 1);

    // R9: jump and branch waiting behind a held reader
    plen = 0;
    ld(5'd5); alu(5'd6, 5'd5, 5'd0); jmp(0); pad();
    ld(5'd5); alu(5'd6, 5'd0, 5'd5); br(0, 0, 1, 0, 0); pad();
    run("R9", 9, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule